// File: doc/BRIEF.md
# MDIO Management Access Controller

This block lets a host reach the management registers of an Ethernet PHY over the two-wire MDIO bus. The host uses two 16-bit registers. For a write it first loads the data register with the value to send. It then writes the command register with the PHY address, the register number, a clock-range code, a direction flag and a start/busy flag. The controller derives MDC from the system clock. It shifts out a complete management frame and releases the shared data line on reads. It collects the returned bits and drops the busy flag when the frame ends. After a read, the data register holds the value returned by the PHY.

The MDC divide ratio is not programmed directly. The host instead states which band the system clock lies in, and the controller picks a ratio that keeps MDC below 2.5 MHz for that band. The bus pads are modelled as a separate output, output-enable and input. The host port is a simple write strobe with a combinational read-back.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the busy flag reads 0, `mdc` and `mdio_oe` are low, and both registers read 0.
- R2: The command register sits at host offset 0x10 with PHY address in bits 15:11, register number in bits 10:6, clock-range code in bits 4:2, write flag in bit 1 (1 = write, 0 = read) and busy in bit 0; bit 5 reads 0; a write with bit 0 clear stores the fields without starting a frame.
- R3: A write to 0x10 with bit 0 set while idle starts a frame; bit 0 then reads 1 until the frame ends and returns to 0 in the same cycle MDC falls for the last time.
- R4: MDC stays low while idle; during a frame each MDC half period lasts half the divide ratio in system clocks, the ratio being 42, 62, 16, 26, 102, 124 for codes 0 to 5 and 124 for codes 6 and 7.
- R5: A frame is 64 MDC periods: 32 ones, start bits 01, opcode 10 for read or 01 for write, 5-bit PHY address, 5-bit register number, turnaround 10 on writes, then 16 data bits, every field MSB first.
- R6: `mdio_o` changes only when MDC falls, so it is steady at every MDC rising edge.
- R7: On a read, `mdio_oe` is low from frame bit 46 (the first turnaround bit) to the end; `mdio_i` is sampled at the MDC rising edges of bits 48 to 63, and the 16 bits, first received as MSB, are in the data register when busy clears.
- R8: The data register sits at host offset 0x14 (bits 15:0) and reads back the last value written; its contents are the write data of the next write frame.
- R9: While busy is set, host writes to either register are ignored: fields, data and the frame on the wire stay unchanged.
- R10: `mdio_oe` is low whenever no frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 8 | Host register offset (0x10 command, 0x14 data) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read-back of the register at `host_addr` |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Value seen on the data line |

## Verification
The assertions take for granted that the PHY leaves the data line alone while `mdio_oe` is high. They also assume that the host changes the command register only through the write strobe, so a steady register view during a frame means that host writes were refused. The bench PHY model drives `mdio_i` only after an MDC falling edge and only during the data bits of a read. All host writes are issued away from the clock edge. Writes during a frame are deliberately aimed at both registers so that the refusal path is exercised.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int PRE_LEN   = 32;
    localparam int FIELD_W   = 5;
    localparam int RANGE_W   = 3;
    localparam int DATA_W    = 16;
    localparam int FRAME_LEN = PRE_LEN + 4 + 2 * FIELD_W + 2 + DATA_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int CNT_W     = 6;

    typedef struct packed {
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regn;
        logic [RANGE_W-1:0] band;
        logic               wr;
    } cmd_t;

    // Terminal count of the half-period counter for each clock band.
    function automatic logic [CNT_W-1:0] half_limit(input logic [RANGE_W-1:0] band);
        int ratio;
        case (band)
            3'd0:    ratio = 42;
            3'd1:    ratio = 62;
            3'd2:    ratio = 16;
            3'd3:    ratio = 26;
            3'd4:    ratio = 102;
            default: ratio = 124;
        endcase
        return CNT_W'(ratio / 2 - 1);
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [RANGE_W-1:0] band,
    output logic               mdc,
    output logic               rise,
    output logic               fall
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        rise  = 1'b0;
        fall  = 1'b0;
        if (!run) begin
            gen_d.cnt = '0;
            gen_d.mdc = 1'b0;
        end else if (gen_q.cnt == half_limit(band)) begin
            gen_d.cnt = '0;
            gen_d.mdc = ~gen_q.mdc;
            rise      = ~gen_q.mdc;
            fall      = gen_q.mdc;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign mdc = gen_q.mdc;
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [FRAME_LEN-1:0] load_bits,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdio_i,
    output logic                 mdio_o,
    output logic [IDX_W-1:0]     idx,
    output logic                 last,
    output logic [DATA_W-1:0]    rd_data
);
    localparam int CAP_FIRST = FRAME_LEN - DATA_W;

    typedef struct packed {
        logic [FRAME_LEN-1:0] shift;
        logic [IDX_W-1:0]     idx;
        logic [DATA_W-1:0]    rdata;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (load) begin
            shf_d.shift = load_bits;
            shf_d.idx   = '0;
            shf_d.rdata = '0;
        end else begin
            if (rise && (int'(shf_q.idx) >= CAP_FIRST))
                shf_d.rdata = {shf_q.rdata[DATA_W-2:0], mdio_i};
            if (fall) begin
                shf_d.shift = {shf_q.shift[FRAME_LEN-2:0], 1'b0};
                shf_d.idx   = shf_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign mdio_o  = shf_q.shift[FRAME_LEN-1];
    assign idx     = shf_q.idx;
    assign last    = fall && (int'(shf_q.idx) == FRAME_LEN - 1);
    assign rd_data = shf_q.rdata;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter logic [7:0] CMD_OFFSET  = 8'h10,
    parameter logic [7:0] DATA_OFFSET = 8'h14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [7:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int RELEASE_IDX = FRAME_LEN - DATA_W - 2;

    typedef struct packed {
        cmd_t              cmd;
        logic              busy;
        logic [DATA_W-1:0] data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 start, rise, fall, last;
    logic [IDX_W-1:0]     idx;
    logic [DATA_W-1:0]    rd_data;
    logic [FRAME_LEN-1:0] frame_bits;
    cmd_t                 cmd_in;
    logic                 busy_w;
    logic [15:0]          reg_view_w;
    logic                 unused_bit5;

    assign cmd_in.phy  = host_wdata[15:11];
    assign cmd_in.regn = host_wdata[10:6];
    assign cmd_in.band = host_wdata[4:2];
    assign cmd_in.wr   = host_wdata[1];
    assign unused_bit5 = host_wdata[5];

    assign start = host_we && (host_addr == CMD_OFFSET) && !ctl_q.busy && host_wdata[0];

    assign frame_bits = {{PRE_LEN{1'b1}}, 2'b01, (cmd_in.wr ? 2'b01 : 2'b10),
                         cmd_in.phy, cmd_in.regn, 2'b10, ctl_q.data};

    always_comb begin
        ctl_d = ctl_q;
        if (!ctl_q.busy && host_we) begin
            if (host_addr == CMD_OFFSET) begin
                ctl_d.cmd  = cmd_in;
                ctl_d.busy = host_wdata[0];
            end else if (host_addr == DATA_OFFSET) begin
                ctl_d.data = host_wdata;
            end
        end
        if (ctl_q.busy && last) begin
            ctl_d.busy = 1'b0;
            if (!ctl_q.cmd.wr) ctl_d.data = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    mdio_mdc_gen u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_q.busy),
        .band  (ctl_q.cmd.band),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_frame_shifter u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_bits (frame_bits),
        .rise      (rise),
        .fall      (fall),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .idx       (idx),
        .last      (last),
        .rd_data   (rd_data)
    );

    assign mdio_oe = ctl_q.busy && (ctl_q.cmd.wr || (int'(idx) < RELEASE_IDX));

    assign reg_view_w = {ctl_q.cmd.phy, ctl_q.cmd.regn, 1'b0, ctl_q.cmd.band,
                         ctl_q.cmd.wr, ctl_q.busy};
    assign busy_w     = ctl_q.busy;

    always_comb begin
        if (host_addr == CMD_OFFSET)       host_rdata = reg_view_w;
        else if (host_addr == DATA_OFFSET) host_rdata = ctl_q.data;
        else                               host_rdata = '0;
    end
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic [15:0] reg_view
);
    // R10: no drive on the data line while idle
    p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // R4: management clock parked low while idle
    p_mdc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R6: the data line does not move on an MDC rising edge
    p_stable_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_o));

    // R9: command fields frozen while a frame runs
    p_frozen_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(reg_view[15:1]));

    // R3: busy ends together with the last MDC falling edge
    p_done_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(mdc));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (busy_w),
    .reg_view (reg_view_w)
);

// File: tb/mdio_mgmt_ctrl_test.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = 8'h10;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mdio_mgmt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int half_of(input int band);
        case (band)
            0: return 21; 1: return 31; 2: return 8;
            3: return 13; 4: return 51; default: return 62;
        endcase
    endfunction

    function automatic logic [63:0] frame_of(input bit wr, input logic [4:0] pa,
                                             input logic [4:0] ra, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), pa, ra, 2'b10, d};
    endfunction

    // Behavioural reference of busy, MDC and drive enable
    int m_busy = 0, m_cnt = 0, m_mdc = 0, m_idx = 0, m_wr = 0, m_half = 1;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_mdc = 0; m_idx = 0;
        end else if (m_busy != 0) begin
            if (m_cnt == m_half - 1) begin
                m_cnt = 0;
                if (m_mdc == 0) m_mdc = 1;
                else begin
                    m_mdc = 0;
                    if (m_idx == 63) m_busy = 0; else m_idx++;
                end
            end else m_cnt++;
        end else if (host_we && host_addr == 8'h10 && host_wdata[0]) begin
            m_busy = 1; m_cnt = 0; m_mdc = 0; m_idx = 0;
            m_wr = host_wdata[1];
            m_half = half_of(int'(host_wdata[4:2]));
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R4 mdc", 64'(mdc), 64'(m_mdc));
            check("R7/R10 mdio_oe", 64'(mdio_oe),
                  64'(m_busy != 0 && (m_wr != 0 || m_idx < 46)));
            if (host_addr == 8'h10) check("R3 busy", 64'(host_rdata[0]), 64'(m_busy));
        end
    end

    // PHY model
    int rise_n = 0;
    logic [63:0] cap = '0;
    logic [15:0] phy_val = '0;
    always @(posedge mdc) begin
        cap = {cap[62:0], (mdio_oe ? mdio_o : 1'b0)};
        rise_n++;
    end
    always @(negedge mdc) begin
        if (rise_n >= 48 && rise_n <= 63) mdio_i = phy_val[63 - rise_n];
        else mdio_i = 1'b1;
    end

    task automatic host_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_addr = 8'h10;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
        host_addr = 8'h10;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (host_rdata[0] == 1'b0) break;
        end
    endtask

    task automatic run_frame(input int band, input bit wr, input logic [4:0] pa,
                             input logic [4:0] ra, input logic [15:0] d, input logic [15:0] pv);
        logic [15:0] rb;
        logic [63:0] ef;
        phy_val = pv;
        if (wr) host_write(8'h14, d);
        rise_n = 0;
        host_write(8'h10, {pa, ra, 1'b0, 3'(band), wr, 1'b1});
        wait_idle();
        ef = frame_of(wr, pa, ra, d);
        if (wr) check("R5 write frame bits", cap, ef);
        else    check("R5 read frame header", 64'(cap[63:18]), 64'(ef[63:18]));
        check("R5 frame length", 64'(rise_n), 64'd64);
        host_read(8'h14, rb);
        if (wr) check("R8 data kept after write", 64'(rb), 64'(d));
        else    check("R7 read data captured", 64'(rb), 64'(pv));
    endtask

    initial begin
        logic [15:0] rb;
        repeat (3) @(negedge clk);
        check("R1 mdc reset", 64'(mdc), 64'd0);
        check("R1 oe reset", 64'(mdio_oe), 64'd0);
        check("R1 cmd reset", 64'(host_rdata), 64'd0);
        rst_n = 1'b1;
        host_read(8'h14, rb);
        check("R1 data reset", 64'(rb), 64'd0);

        // R2: store fields without starting
        host_write(8'h10, {5'h13, 5'h0A, 1'b1, 3'd5, 1'b1, 1'b0});
        host_read(8'h10, rb);
        check("R2 field readback", 64'(rb), 64'({5'h13, 5'h0A, 1'b0, 3'd5, 1'b1, 1'b0}));
        repeat (200) @(negedge clk);
        check("R2 no frame started", 64'(mdc), 64'd0);

        host_write(8'h14, 16'h1234);
        host_read(8'h14, rb);
        check("R8 data readback", 64'(rb), 64'h1234);

        run_frame(2, 1'b1, 5'h11, 5'h04, 16'hA5C3, 16'h0000);
        run_frame(2, 1'b0, 5'h01, 5'h02, 16'h0000, 16'h3C5A);
        run_frame(3, 1'b0, 5'h1F, 5'h1F, 16'h0000, 16'h8001);
        run_frame(0, 1'b1, 5'h00, 5'h00, 16'hFFFF, 16'h0000);
        run_frame(1, 1'b0, 5'h0A, 5'h15, 16'h0000, 16'hFFFF);
        run_frame(4, 1'b1, 5'h15, 5'h0A, 16'h0001, 16'h0000);
        run_frame(5, 1'b0, 5'h07, 5'h1C, 16'h0000, 16'hC3A5);
        run_frame(7, 1'b1, 5'h02, 5'h01, 16'h5A5A, 16'h0000);

        // R9: writes during a frame are ignored
        host_write(8'h14, 16'hBEEF);
        rise_n = 0;
        host_write(8'h10, {5'h09, 5'h06, 1'b0, 3'd2, 1'b1, 1'b1});
        repeat (100) @(negedge clk);
        host_write(8'h10, {5'h1F, 5'h1F, 1'b0, 3'd0, 1'b0, 1'b1});
        host_write(8'h14, 16'h0F0F);
        host_read(8'h10, rb);
        check("R9 cmd unchanged while busy", 64'(rb), 64'({5'h09, 5'h06, 1'b0, 3'd2, 1'b1, 1'b1}));
        host_read(8'h14, rb);
        check("R9 data unchanged while busy", 64'(rb), 64'hBEEF);
        wait_idle();
        check("R9 frame unchanged", cap, frame_of(1'b1, 5'h09, 5'h06, 16'hBEEF));
        check("R10 idle oe", 64'(mdio_oe), 64'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++; mismatched++;
            $display("FAIL watchdog R3 actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule